// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Row Refresh

This controller sits between a host that issues single-word reads and writes and an external asynchronous DRAM. The DRAM takes its row and column addresses on one shared set of address pins and is steered by four active-low strobes: row strobe, column strobe, write enable and output enable. Each host address is split into a row part and a column part. The row goes out first under a falling row strobe. The column follows under a falling column strobe.

After an access the row is left open. A later request to the same row costs only a column cycle. A request to another row closes the page, waits out a precharge interval and opens the new row. A page open-time limit closes a row that has been held too long, even while requests keep hitting it. A free-running refresh timer raises a refresh request at a fixed interval. Each refresh opens the next row of a sweeping counter with a row strobe only, so no column access takes place. Host traffic waits while a refresh runs, and a refresh that comes due forces any open page closed.

All strobe timings are parameters counted in clock cycles. Host requests use a valid/ready pair. Read data comes back on a one-cycle valid pulse.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all four strobes are high, `dram_dq_oe` is low, and `req_ready` and `rd_valid` are low.
- R2: The row part `req_addr[ROW_W+COL_W-1:COL_W]`, zero-extended, is on `dram_addr` when the row strobe falls. The column part `req_addr[COL_W-1:0]` is on `dram_addr` when the column strobe falls. Write data is on `dram_dq_out` with `dram_dq_oe` high while the column strobe is low. A word written and then read at the same address returns the written value.
- R3: The column strobe is low only while the row strobe is low. At least T_RCD clock cycles separate a row strobe fall from the first column strobe fall after it.
- R4: Writes are early writes: write enable is already low in the cycle before the column strobe falls. Reads are early reads: output enable is already low in the cycle before the column strobe falls.
- R5: A request to the row that is open is served with a column cycle only, with no new row strobe fall. `req_ready` rises only while a row is open and the column strobe is high.
- R6: The row strobe stays high for at least T_RP clock cycles before it falls again.
- R7: Every accepted read yields exactly one `rd_valid` pulse, in request order. Each pulse comes at the end of that read's column strobe window.
- R8: A refresh holds the row strobe low for exactly T_RFSH cycles, with no column strobe fall. The rows refreshed run 0, 1, 2, … and wrap modulo 2^ROW_W. One refresh is requested every REF_INTERVAL cycles. Data held in the DRAM is not changed by refreshes.
- R9: A pending refresh closes an open page after at most one further access, and it runs before any waiting host request. Two consecutive refresh row-strobe falls are never more than REF_INTERVAL+T_RCD+T_CAS+T_CP+T_RP+10 cycles apart.
- R10: A host-opened row stays open no longer than T_PAGE_MAX+T_CAS+T_CP+2 cycles of row strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request taken at this clock edge |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench runs a burst of hits to one row and compares the number of row strobe falls against the number of column strobe falls. A design that reopened the row on every access would show as many row opens as accesses. Row-alternating traffic checks the precharge gap and the row/column multiplexing through read-back of the bench's DRAM model; swapped or misaligned address halves would return wrong words. A long stream of hits checks the open-time limit. Mixed traffic checks that refresh windows carry no column cycle, sweep the rows in order and keep their spacing. A controller that let refresh wait for the page to close naturally, or that let host traffic win, would stretch the refresh gap past its bound.

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 8,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 2,
  parameter int T_RP         = 3,
  parameter int T_RFSH       = 4,
  parameter int T_PAGE_MAX   = 40,
  parameter int REF_INTERVAL = 64,
  localparam int HA = ROW_W + COL_W,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [HA-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_OPEN, S_COLSET, S_CAS, S_CASPRE, S_PRE, S_REF
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt, page_timer, ref_timer;
  logic [ROW_W-1:0] open_row, ref_row;
  logic             ref_pend, fresh, op_wr;

  wire [ROW_W-1:0] req_row   = req_addr[HA-1:COL_W];
  wire [COL_W-1:0] req_col   = req_addr[COL_W-1:0];
  wire             hit       = req_valid && (req_row == open_row);
  wire             expired   = page_timer >= CNT_W'(T_PAGE_MAX);
  wire             close_now = (ref_pend || expired) && !(fresh && hit);
  wire             ref_tick  = ref_timer == CNT_W'(REF_INTERVAL - 1);
  wire             cnt_done  = cnt == '0;

  assign req_ready = (state == S_OPEN) && hit && !close_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      page_timer  <= '0;
      ref_timer   <= '0;
      open_row    <= '0;
      ref_row     <= '0;
      ref_pend    <= 1'b0;
      fresh       <= 1'b0;
      op_wr       <= 1'b0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid   <= 1'b0;
      ref_timer  <= ref_tick ? '0 : ref_timer + 1'b1;
      page_timer <= dram_ras_n ? '0 : page_timer + 1'b1;
      if (ref_tick) ref_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            state      <= S_REF;
            dram_ras_n <= 1'b0;
            dram_addr  <= AW'(ref_row);
            cnt        <= CNT_W'(T_RFSH - 1);
            ref_pend   <= 1'b0;
          end else if (req_valid) begin
            state      <= S_ACT;
            dram_ras_n <= 1'b0;
            dram_addr  <= AW'(req_row);
            open_row   <= req_row;
            fresh      <= 1'b1;
            cnt        <= CNT_W'(T_RCD - 1);
          end
        end
        S_ACT: begin
          if (cnt_done) state <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_OPEN: begin
          if (req_ready) begin
            state       <= S_COLSET;
            dram_addr   <= AW'(req_col);
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            op_wr       <= req_write;
            fresh       <= 1'b0;
          end else if (close_now || (req_valid && !hit)) begin
            state      <= S_PRE;
            dram_ras_n <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
          end
        end
        S_COLSET: begin
          state      <= S_CAS;
          dram_cas_n <= 1'b0;
          cnt        <= CNT_W'(T_CAS - 1);
        end
        S_CAS: begin
          if (cnt_done) begin
            state      <= S_CASPRE;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            cnt        <= CNT_W'(T_CP - 1);
            if (!op_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_CASPRE: begin
          if (cnt_done) state <= S_OPEN;
          else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (cnt_done) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (cnt_done) begin
            state      <= S_PRE;
            dram_ras_n <= 1'b1;
            ref_row    <= ref_row + 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst) !dram_cas_n |-> !dram_ras_n); // R3
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst) ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R4
  AST_EARLY_READ: assert property (@(posedge clk) disable iff (rst) ($fell(dram_cas_n) && !dram_oe_n) |-> $past(!dram_oe_n)); // R4
  AST_READY_IN_PAGE: assert property (@(posedge clk) disable iff (rst) req_ready |-> (!dram_ras_n && dram_cas_n)); // R5
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst) ($rose(dram_ras_n) && (T_RP > 1)) |=> dram_ras_n); // R6
  AST_RD_AFTER_CAS: assert property (@(posedge clk) disable iff (rst) rd_valid |-> (dram_cas_n && $past(!dram_cas_n))); // R7
  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (rst) !dram_ras_n |-> (page_timer < CNT_W'(T_PAGE_MAX + T_CAS + T_CP + 2))); // R10

endmodule

// File: tb/dram_page_ctrl_tb_top.sv
module dram_page_ctrl_tb_top;
  localparam int ROW_W = 4, COL_W = 4, DW = 8;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3, T_RFSH = 4;
  localparam int T_PAGE_MAX = 40, REF_INTERVAL = 64;
  localparam int HA = ROW_W + COL_W;
  localparam int PAGE_BOUND = T_PAGE_MAX + T_CAS + T_CP + 2;
  localparam int GAP_BOUND = REF_INTERVAL + T_RCD + T_CAS + T_CP + T_RP + 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [HA-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
  logic [3:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;

  always #5 clk = ~clk;

  dram_page_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in));

  // DRAM model and strobe monitor
  logic [DW-1:0] mem [0:(1<<HA)-1];
  logic [ROW_W-1:0] lat_row = '0;
  logic [COL_W-1:0] lat_col = '0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_oe = 1'b1;
  int cyc = 0, low_len = 0, high_len = 0, fall_cyc = 0, last_ref = 0;
  bit seen_rise = 0, cas_in_win = 0, have_ref = 0;
  int ras_falls = 0, cas_falls = 0, ref_cnt = 0;
  int ref_exp = 0;
  int rcd_viol = 0, early_viol = 0, rp_viol = 0, refrow_viol = 0, reflen_viol = 0;
  int gap_viol = 0, page_viol = 0, wdata_viol = 0;

  assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[{lat_row, lat_col}] : '0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1<<HA); i++) mem[i] = DW'(i * 37 + 5);
      cyc = 0;
    end else begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        lat_row = dram_addr[ROW_W-1:0];
        cas_in_win = 0;
        fall_cyc = cyc;
        if (seen_rise && high_len < T_RP) rp_viol++;
        low_len = 1;
      end else if (!dram_ras_n) low_len++;
      if (!p_ras && dram_ras_n) begin
        seen_rise = 1;
        high_len = 1;
        if (!cas_in_win) begin
          if (int'(lat_row) != ref_exp) refrow_viol++;
          if (low_len != T_RFSH) reflen_viol++;
          if (have_ref && (fall_cyc - last_ref) > GAP_BOUND) gap_viol++;
          last_ref = fall_cyc;
          have_ref = 1;
          ref_exp = (ref_exp + 1) % (1 << ROW_W);
          ref_cnt++;
        end else if (low_len > PAGE_BOUND) page_viol++;
      end else if (dram_ras_n) high_len++;
      if (p_cas && !dram_cas_n) begin
        cas_falls++;
        cas_in_win = 1;
        lat_col = dram_addr[COL_W-1:0];
        if (dram_ras_n || (low_len - 1) < T_RCD) rcd_viol++;
        if ((!dram_we_n && p_we) || (!dram_oe_n && p_oe)) early_viol++;
        if (!dram_we_n) begin
          if (!dram_dq_oe) wdata_viol++;
          mem[{lat_row, lat_col}] = dram_dq_out;
        end
      end
      if (!dram_cas_n && dram_ras_n) rcd_viol++;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_oe = dram_oe_n;
    end
  end

  // Scoreboard monitor
  logic [DW-1:0] exp_q[$];
  int rd_tests = 0, rd_fails = 0;
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      rd_tests++;
      if (exp_q.size() == 0) begin
        rd_fails++;
        $display("FAIL R7 unexpected read pulse: act %0h exp none", rd_data);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          rd_fails++;
          $display("FAIL R2 R7 read data: act %0h exp %0h", rd_data, e);
        end
      end
    end
  end

  int tests = 0, failed = 0;
  logic [DW-1:0] shadow [0:(1<<HA)-1];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: act %0d exp %0d", tag, what, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [HA-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (wr) shadow[a] = d;
    else exp_q.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int rf0, cf0, rc0, lcg;
    for (int i = 0; i < (1<<HA); i++) shadow[i] = DW'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !req_ready && !rd_valid, "R1", "outputs idle in reset",
        {dram_dq_oe, req_ready, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n, "R1", "strobes high after reset", {dram_ras_n, dram_cas_n}, 3);

    // R2 R7: scattered writes and reads
    op(1, 8'h12, 8'hA1); op(1, 8'h9C, 8'h3B); op(1, 8'hF0, 8'h77); op(1, 8'h13, 8'h5E);
    op(0, 8'h12, 0); op(0, 8'h9C, 0); op(0, 8'hF0, 0); op(0, 8'h13, 0); op(0, 8'h44, 0);
    idle(60);

    // R5: hit burst on one row from a closed page
    while (!dram_ras_n) @(negedge clk);
    rf0 = ras_falls; cf0 = cas_falls; rc0 = ref_cnt;
    op(1, 8'h30, 8'h11); op(0, 8'h31, 0); op(1, 8'h3F, 8'h22); op(0, 8'h30, 0); op(0, 8'h3F, 0);
    idle(60);
    chk(cas_falls - cf0 == 5, "R5", "column cycles in burst", cas_falls - cf0, 5);
    chk((ras_falls - rf0) - (ref_cnt - rc0) <= 1 + (ref_cnt - rc0), "R5", "host row opens in burst",
        (ras_falls - rf0) - (ref_cnt - rc0), 1 + (ref_cnt - rc0));

    // R6: alternating rows force misses
    rf0 = ras_falls; rc0 = ref_cnt;
    for (int i = 0; i < 6; i++) op(i[0], {4'(1 + i[0]), 4'(i)}, 8'(8'hC0 + i));
    for (int i = 0; i < 6; i++) op(0, {4'(1 + i[0]), 4'(i)}, 0);
    idle(20);
    chk((ras_falls - rf0) - (ref_cnt - rc0) >= 12, "R6", "row opens for misses",
        (ras_falls - rf0) - (ref_cnt - rc0), 12);

    // R10: long stream of hits to one row
    for (int i = 0; i < 30; i++) op(i[1], {4'h7, 4'(i)}, 8'(i * 3));
    idle(60);
    chk(page_viol == 0, "R10", "page open windows over limit", page_viol, 0);

    // R8 R9: mixed traffic with refresh
    lcg = 7;
    for (int i = 0; i < 300; i++) begin
      lcg = (lcg * 69069 + 1) & 32'h7fffffff;
      op(lcg[20], {2'b0, lcg[9:8], lcg[13:10]}, lcg[31:24]);
    end
    for (int i = 0; i < 64; i++) op(0, 8'(i * 4), 0);
    idle(40);

    chk(exp_q.size() == 0, "R7", "reads left without data", exp_q.size(), 0);
    chk(rcd_viol == 0, "R3", "column strobe timing violations", rcd_viol, 0);
    chk(early_viol == 0, "R4", "late write/read strobes", early_viol, 0);
    chk(wdata_viol == 0, "R2", "write data not driven", wdata_viol, 0);
    chk(rp_viol == 0, "R6", "short precharge", rp_viol, 0);
    chk(refrow_viol == 0, "R8", "refresh row order errors", refrow_viol, 0);
    chk(reflen_viol == 0, "R8", "refresh length errors", reflen_viol, 0);
    chk(ref_cnt >= cyc / REF_INTERVAL - 1, "R8", "refresh count", ref_cnt, cyc / REF_INTERVAL - 1);
    chk(gap_viol == 0, "R9", "refresh gaps over bound", gap_viol, 0);
    chk(page_viol == 0, "R10", "page open windows over limit", page_viol, 0);

    $display("[TB] %0d tests run, %0d failed", tests + rd_tests, failed + rd_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: act timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests + rd_tests + 1, failed + rd_fails + 1);
    $finish;
  end
endmodule